// File: doc/BRIEF.md
# Iterative Eight-Round Feistel Block Cipher Core

This block enciphers one 64-bit block under a 128-bit key with an eight-round Feistel network. It computes one round per clock. A single FL instance and a single FO port are shared by every round. The left 32-bit half passes through FL and FO. Odd rounds apply FL first and even rounds apply FO first. The result is XORed into the right half, and then the halves swap. The round subkeys are derived inside the block from the latched key words, the eight fixed mask constants and the round index.

The non-linear FO mixing function is kept outside the core. The core drives the FO operand and the 48-bit KO and KI subkeys on output ports, and it takes the 32-bit FO result back on an input port in the same cycle. The FO function is therefore a combinational neighbour that the surrounding design instantiates next to the core. A one-cycle trigger pulse starts a block. The done flag then holds the finished ciphertext until the next accepted trigger.

Top module: `feistel_round_core`

## Requirements
- R1: While the active-low reset `rst_n` is low, `done` is 0 and `dout` is all zeros.
- R2: Sampling `trig` high while no block is in progress loads `din` and `key` and clears `done`. `done` then rises on the eighth rising clock edge after the loading edge.
- R3: Rounds are numbered 1 to 8, and round 1 is the first round after the load. In odd rounds the FL output is the FO operand and the FO result is the round function. In even rounds the left half is the FO operand and FL applied to the FO result is the round function.
- R4: FL splits its 32-bit input into an upper half L and a lower half R, and it splits KL the same way into KLa (upper) and KLb (lower). R' = R xor rotl1(L and KLa), then L' = L xor rotl1(R' or KLb), and the output is {L', R'}.
- R5: `din[63:32]` is the initial left half. Each round sets new left = old right xor round function and new right = old left. `dout` is {left, right}.
- R6: The key is split into words K0..K7, with K0 = `key[127:112]`. Kp[w] = K[w] xor M[w], where M = 0123, 4567, 89AB, CDEF, FEDC, BA98, 7654, 3210 (hex). For zero-based round r, with indices taken mod 8: KL = {rotl1(K[r]), Kp[r+2]}, KO = {rotl5(K[r+1]), rotl8(K[r+5]), rotl13(K[r+6])} and KI = {Kp[r+4], K[r+3], K[r+7]}. The first field of each is the most significant.
- R7: `trig` sampled while a block is in progress is ignored. This includes the edge that completes the eighth round.
- R8: While `done` is high and `trig` is low, `dout` and `done` hold their values whatever `din` and `key` do.
- R9: In the cycle after the load, `fo_in` equals FL(`din[63:32]`, round-1 KL), and `fo_ko` and `fo_ki` carry the round-1 KO and KI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Start pulse, accepted when idle |
| din | input | 64 | Plaintext block |
| key | input | 128 | Cipher key |
| dout | output | 64 | Result block, valid while done is high |
| done | output | 1 | Block finished, result held |
| fo_in | output | 32 | Operand sent to the external FO function |
| fo_ko | output | 48 | KO subkey for the current round |
| fo_ki | output | 48 | KI subkey for the current round |
| fo_out | input | 32 | Combinational result of the external FO function |

## Verification
The hardest situation to reach from the ports is a trigger that arrives on the very edge that finishes round eight. At that moment the core is still busy, yet it is about to become idle. The stimulus counts seven cycles after a load and then raises `trig` with different data and key for exactly that edge. It then confirms that the first block's result appears and stays put. A trigger in the middle of a block and back-to-back triggers on a finished block round this out. The bench drives the FO port with its own test function so that the alternating FL/FO ordering affects the result.

// File: rtl/fcore_pkg.sv
package fcore_pkg;
   localparam int unsigned SUBW = 16;
   localparam int unsigned NSUB = 8;

   typedef logic [SUBW-1:0] sub_t;

   typedef struct packed {
      logic [2*SUBW-1:0] kl;
      logic [3*SUBW-1:0] ko;
      logic [3*SUBW-1:0] ki;
   } rkeys_t;

   function automatic sub_t rotl(input sub_t x, input int unsigned n);
      return sub_t'((x << n) | (x >> (SUBW - n)));
   endfunction

   function automatic sub_t mask_word(input int unsigned idx);
      case (idx)
         0: return 16'h0123;
         1: return 16'h4567;
         2: return 16'h89AB;
         3: return 16'hCDEF;
         4: return 16'hFEDC;
         5: return 16'hBA98;
         6: return 16'h7654;
         default: return 16'h3210;
      endcase
   endfunction
endpackage

// File: rtl/fcore_fl.sv
module fcore_fl #(
   parameter int unsigned HALF_W = 32
) (
   input  logic [HALF_W-1:0] x,
   input  logic [HALF_W-1:0] kl,
   output logic [HALF_W-1:0] y
);
   localparam int unsigned Q = HALF_W / 2;

   logic [Q-1:0] l_in, r_in, r_and, l_or, r_mix, l_mix;

   assign l_in  = x[HALF_W-1:Q];
   assign r_in  = x[Q-1:0];
   assign r_and = l_in & kl[HALF_W-1:Q];
   assign r_mix = r_in ^ {r_and[Q-2:0], r_and[Q-1]};
   assign l_or  = r_mix | kl[Q-1:0];
   assign l_mix = l_in ^ {l_or[Q-2:0], l_or[Q-1]};
   assign y     = {l_mix, r_mix};
endmodule

// File: rtl/fcore_keysched.sv
module fcore_keysched
   import fcore_pkg::*;
#(
   parameter int unsigned KEY_W = 128,
   parameter int unsigned RND_W = 3
) (
   input  logic [KEY_W-1:0] key,
   input  logic [RND_W-1:0] rnd,
   output rkeys_t           sk
);
   sub_t kw [NSUB];
   sub_t kx [NSUB];

   for (genvar w = 0; w < NSUB; w++) begin : g_words
      assign kw[w] = key[KEY_W-1-w*SUBW -: SUBW];
      assign kx[w] = kw[w] ^ mask_word(w);
   end

   always_comb begin
      sk.kl = {rotl(kw[3'(rnd)], 1), kx[3'(rnd + 3'd2)]};
      sk.ko = {rotl(kw[3'(rnd + 3'd1)], 5),
               rotl(kw[3'(rnd + 3'd5)], 8),
               rotl(kw[3'(rnd + 3'd6)], 13)};
      sk.ki = {kx[3'(rnd + 3'd4)], kw[3'(rnd + 3'd3)], kw[3'(rnd + 3'd7)]};
   end
endmodule

// File: rtl/fcore_seq.sv
module fcore_seq #(
   parameter int unsigned ROUNDS = 8,
   parameter int unsigned RND_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   output logic             load,
   output logic             step,
   output logic             busy,
   output logic             done,
   output logic [RND_W-1:0] rnd
);
   localparam logic [RND_W-1:0] LAST = RND_W'(ROUNDS - 1);

   assign load = trig && !busy;
   assign step = busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         rnd  <= '0;
      end else if (load) begin
         busy <= 1'b1;
         done <= 1'b0;
         rnd  <= '0;
      end else if (step) begin
         rnd <= rnd + 1'b1;
         if (rnd == LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/feistel_round_core.sv
module feistel_round_core
   import fcore_pkg::*;
#(
   parameter int unsigned BLOCK_W = 64,
   parameter int unsigned KEY_W   = 128,
   parameter int unsigned ROUNDS  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 trig,
   input  logic [BLOCK_W-1:0]   din,
   input  logic [KEY_W-1:0]     key,
   output logic [BLOCK_W-1:0]   dout,
   output logic                 done,
   output logic [BLOCK_W/2-1:0] fo_in,
   output logic [3*SUBW-1:0]    fo_ko,
   output logic [3*SUBW-1:0]    fo_ki,
   input  logic [BLOCK_W/2-1:0] fo_out
);
   localparam int unsigned HALF_W = BLOCK_W / 2;
   localparam int unsigned RND_W  = $clog2(ROUNDS);

   if (ROUNDS != 8 || BLOCK_W != 4 * SUBW || KEY_W != NSUB * SUBW) begin : g_bad_cfg
      $error("feistel_round_core: unsupported ROUNDS/BLOCK_W/KEY_W");
   end

   logic              load, step, busy;
   logic [RND_W-1:0]  rnd;
   logic [HALF_W-1:0] left, right, fl_in, fl_out, rfun;
   logic [KEY_W-1:0]  key_q;
   logic              odd_rnd;
   rkeys_t            sk;

   fcore_seq #(.ROUNDS(ROUNDS), .RND_W(RND_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .trig(trig), .load(load), .step(step),
      .busy(busy), .done(done), .rnd(rnd)
   );

   fcore_keysched #(.KEY_W(KEY_W), .RND_W(RND_W)) u_ks (
      .key(key_q), .rnd(rnd), .sk(sk)
   );

   fcore_fl #(.HALF_W(HALF_W)) u_fl (
      .x(fl_in), .kl(sk.kl), .y(fl_out)
   );

   assign odd_rnd = (rnd[0] == 1'b0);
   assign fl_in   = odd_rnd ? left   : fo_out;
   assign fo_in   = odd_rnd ? fl_out : left;
   assign rfun    = odd_rnd ? fo_out : fl_out;
   assign fo_ko   = sk.ko;
   assign fo_ki   = sk.ki;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left  <= '0;
         right <= '0;
         key_q <= '0;
      end else if (load) begin
         left  <= din[BLOCK_W-1:HALF_W];
         right <= din[HALF_W-1:0];
         key_q <= key;
      end else if (step) begin
         left  <= right ^ rfun;
         right <= left;
      end
   end

   assign dout = {left, right};
endmodule

// File: rtl/fcore_chk.sv
module fcore_chk #(
   parameter int unsigned BLOCK_W = 64,
   parameter int unsigned KEY_W   = 128,
   parameter int unsigned ROUNDS  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               trig,
   input logic               busy,
   input logic               done,
   input logic [BLOCK_W-1:0] dout,
   input logic [KEY_W-1:0]   key_q
);
   localparam int unsigned CW = $clog2(ROUNDS + 1) + 1;

   logic [CW-1:0] lat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                lat_cnt <= '0;
      else if (trig && !busy)    lat_cnt <= '0;
      else if (busy)             lat_cnt <= lat_cnt + 1'b1;
   end

   // R2: done rises exactly ROUNDS busy cycles after the load
   assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (lat_cnt == CW'(ROUNDS)));

   // R2: a finished flag never coexists with a block in progress
   assert_done_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy));

   // R7: a trigger while busy leaves the latched key untouched
   assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && trig) |=> $stable(key_q));

   // R8: result and flag hold while no new trigger arrives
   assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !trig) |=> ($stable(dout) && done));
endmodule

bind feistel_round_core fcore_chk #(
   .BLOCK_W(BLOCK_W), .KEY_W(KEY_W), .ROUNDS(ROUNDS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .trig(trig), .busy(busy), .done(done),
   .dout(dout), .key_q(key_q)
);

// File: tb/feistel_round_core_tb_top.sv
module feistel_round_core_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         trig = 1'b0;
   logic [63:0]  din = '0;
   logic [127:0] key = '0;
   logic [63:0]  dout;
   logic         done;
   logic [31:0]  fo_in, fo_out;
   logic [47:0]  fo_ko, fo_ki;
   int           checks = 0;
   int           errors = 0;

   always #10 clk = ~clk;

   localparam logic [15:0] MK [8] = '{16'h0123, 16'h4567, 16'h89AB, 16'hCDEF,
                                      16'hFEDC, 16'hBA98, 16'h7654, 16'h3210};

   localparam int NV = 6;
   localparam logic [191:0] VEC [NV] = '{
      {64'h0000000000000000, 128'h0},
      {64'hFFFFFFFFFFFFFFFF, {128{1'b1}}},
      {64'h0123456789ABCDEF, 128'h00112233445566778899AABBCCDDEEFF},
      {64'hFEDCBA9876543210, 128'h0123456789ABCDEFFEDCBA9876543210},
      {64'h8000000000000001, 128'h80000000000000000000000000000001},
      {64'hDEADBEEFCAFEF00D, 128'h13579BDF2468ACE0F1E2D3C4B5A69788}
   };

   function automatic logic [15:0] r16(input logic [15:0] x, input int n);
      return (x << n) | (x >> (16 - n));
   endfunction

   function automatic logic [31:0] m_fl(input logic [31:0] x, input logic [31:0] kl);
      logic [15:0] l, r;
      l = x[31:16];
      r = x[15:0];
      r = r ^ r16(l & kl[31:16], 1);
      l = l ^ r16(r | kl[15:0], 1);
      return {l, r};
   endfunction

   // Test stand-in for the external FO function: non-linear through the add.
   function automatic logic [31:0] m_fo(input logic [31:0] x, input logic [47:0] ko,
                                        input logic [47:0] ki);
      logic [31:0] t;
      t = x ^ ko[47:16];
      t = {t[18:0], t[31:19]} + {ki[47:32], ki[15:0]};
      t = t ^ {ko[15:0], ki[31:16]};
      return t ^ (t >> 7);
   endfunction

   // Returns {KL, KO, KI} for zero-based round r.
   function automatic logic [127:0] m_keys(input logic [127:0] k, input int r);
      logic [15:0] kw [8];
      logic [15:0] kx [8];
      for (int w = 0; w < 8; w++) begin
         kw[w] = k[127 - 16*w -: 16];
         kx[w] = kw[w] ^ MK[w];
      end
      return {r16(kw[r % 8], 1), kx[(r + 2) % 8],
              r16(kw[(r + 1) % 8], 5), r16(kw[(r + 5) % 8], 8), r16(kw[(r + 6) % 8], 13),
              kx[(r + 4) % 8], kw[(r + 3) % 8], kw[(r + 7) % 8]};
   endfunction

   function automatic logic [63:0] m_enc(input logic [63:0] d, input logic [127:0] k);
      logic [31:0]  l, r, f;
      logic [127:0] s;
      l = d[63:32];
      r = d[31:0];
      for (int i = 0; i < 8; i++) begin
         s = m_keys(k, i);
         if (i % 2 == 0) f = m_fo(m_fl(l, s[127:96]), s[95:48], s[47:0]);
         else            f = m_fl(m_fo(l, s[95:48], s[47:0]), s[127:96]);
         {l, r} = {r ^ f, l};
      end
      return {l, r};
   endfunction

   assign fo_out = m_fo(fo_in, fo_ko, fo_ki);

   feistel_round_core dut_i (
      .clk(clk), .rst_n(rst_n), .trig(trig), .din(din), .key(key),
      .dout(dout), .done(done), .fo_in(fo_in), .fo_ko(fo_ko), .fo_ki(fo_ki),
      .fo_out(fo_out)
   );

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // Starts a block at a negedge; returns at the negedge after the loading edge.
   task automatic start(input logic [63:0] d, input logic [127:0] k);
      trig = 1'b1;
      din  = d;
      key  = k;
      @(negedge clk);
      trig = 1'b0;
   endtask

   initial begin
      logic [127:0] s0;
      logic [63:0]  exp_a;
      repeat (3) @(negedge clk);
      check("R1 done in reset", 128'(done), 128'(0));
      check("R1 dout in reset", 128'(dout), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // Vector table walk, back to back (R2 R3 R4 R5 R6 R9)
      for (int v = 0; v < NV; v++) begin
         start(VEC[v][191:128], VEC[v][127:0]);
         s0 = m_keys(VEC[v][127:0], 0);
         check("R2 done cleared on load", 128'(done), 128'(0));
         check("R9 fo_in round 1", 128'(fo_in),
               128'(m_fl(VEC[v][191:160], s0[127:96])));
         check("R6 R9 fo_ko round 1", 128'(fo_ko), 128'(s0[95:48]));
         check("R6 R9 fo_ki round 1", 128'(fo_ki), 128'(s0[47:0]));
         repeat (7) @(negedge clk);
         check("R2 done not before eighth edge", 128'(done), 128'(0));
         @(negedge clk);
         check("R2 done after eighth edge", 128'(done), 128'(1));
         check("R3 R4 R5 R6 result", 128'(dout), 128'(m_enc(VEC[v][191:128], VEC[v][127:0])));
      end

      // R7: trigger in the middle of a block is ignored
      exp_a = m_enc(64'h1122334455667788, 128'hA5A5A5A55A5A5A5A0F0F0F0FF0F0F0F0);
      start(64'h1122334455667788, 128'hA5A5A5A55A5A5A5A0F0F0F0FF0F0F0F0);
      @(negedge clk);
      trig = 1'b1;
      din  = 64'hCAFEBABE00000000;
      key  = 128'h1;
      @(negedge clk);
      trig = 1'b0;
      repeat (5) @(negedge clk);
      check("R7 mid-block trigger no early done", 128'(done), 128'(0));
      @(negedge clk);
      check("R7 done on schedule", 128'(done), 128'(1));
      check("R7 result of first block", 128'(dout), 128'(exp_a));

      // R8: result holds while inputs wander
      for (int i = 0; i < 5; i++) begin
         din = {32'(i * 32'h9E3779B9), 32'(~i)};
         key = {4{32'(i * 32'h7F4A7C15)}};
         @(negedge clk);
         check("R8 done held", 128'(done), 128'(1));
         check("R8 dout held", 128'(dout), 128'(exp_a));
      end

      // R7: trigger on the edge that completes round eight
      exp_a = m_enc(64'h0F1E2D3C4B5A6978, 128'hFFEEDDCCBBAA99887766554433221100);
      start(64'h0F1E2D3C4B5A6978, 128'hFFEEDDCCBBAA99887766554433221100);
      repeat (7) @(negedge clk);
      trig = 1'b1;
      din  = 64'h0;
      key  = 128'h0;
      @(negedge clk);
      trig = 1'b0;
      check("R7 last-edge trigger done", 128'(done), 128'(1));
      check("R7 last-edge trigger result", 128'(dout), 128'(exp_a));
      @(negedge clk);
      check("R7 R8 no restart after last edge", 128'(done), 128'(1));
      check("R7 R8 result still held", 128'(dout), 128'(exp_a));

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule